// File: doc/BRIEF.md
# Keyed-Disable Watchdog Timer

This block is a register-mapped watchdog. Software loads a timeout value, turns the watchdog on through a control word, and must then restart ("kick") the countdown before it runs out. If the remaining count reaches zero, the block sets a sticky expiry flag and raises a one-cycle pulse on one of three event lines: a system-reset request, a non-maskable interrupt request or a general interrupt request. Software can also select no event at all.

The watchdog is turned off only when one exact 8-bit key is present in a field of the control word. Any other value in that field keeps it running. So a stray write of zero to the control register enables the watchdog with the reset action selected. The expiry flag sits in bit 15 of the same word and is cleared by writing a one to it.

The core is a three-state machine. OFF holds the count. RUN decrements once per clock. EXPIRED holds the count at zero. The named transitions are:
- OFF→RUN (arm): the field leaves the key value, and the count is loaded from the timeout register.
- RUN→RUN (kick): a write to the status address reloads the count.
- RUN→EXPIRED (fire): the count runs out.
- EXPIRED→RUN (kick): a status write reloads the count.
- RUN/EXPIRED→OFF (disarm): the key is written.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the control word reads 0x0AD0 (disabled, reset action, flag clear). The timeout register reads the RST_TIMEOUT parameter, the status register reads 0, and all three event outputs and `expired` are low.
- R2: When control bits 11:4 hold 0xAD the watchdog is disabled. The remaining count (status) holds its value and no event fires.
- R3: Any other value in bits 11:4 enables counting. Writing 0x0000 to control enables the watchdog with the reset action.
- R4: One clock after the write that enables a disabled watchdog, status equals the timeout register. It then falls by one on every clock.
- R5: With timeout P, status reaches 0 P clocks after loading. In that same cycle `expired` (control bit 15) goes high and the selected event output is high for exactly one cycle. Status then stays at 0.
- R6: Control bits 2:1 select the event: 00 asserts `rst_req`, 01 asserts `nmi_req`, 10 asserts `irq_req`, 11 asserts none. At most one event output is high at a time.
- R7: Writing control with bit 15 set clears the expiry flag. Writing it with bit 15 clear leaves the flag unchanged. Writing 0x8AD6 clears the flag and keeps the watchdog disabled.
- R8: Any write to address 2 (status) while enabled reloads status from the timeout register on that clock. This also restarts counting from the EXPIRED state, and the flag stays set. The same write while disabled has no effect.
- R9: Writes to address 1 (timeout) are accepted while disabled and ignored while enabled.
- R10: The register map is: address 0 control, address 1 timeout, address 2 status, address 3 reads 0. Control reads back as {flag, 000, field[7:0], 0, sel[1:0], 0}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the count steps once per rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe, single cycle |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for bus_addr (combinational) |
| rst_req | output | 1 | System-reset request pulse |
| nmi_req | output | 1 | Non-maskable interrupt request pulse |
| irq_req | output | 1 | General interrupt request pulse |
| expired | output | 1 | Sticky expiry flag (control bit 15) |

## Verification
The bench builds the block with a 32-bit count and the 0xAD key, but lowers RST_TIMEOUT to 20. This lets the watchdog, once enabled straight out of reset, reach expiry with its reset-time timeout in a few cycles. Timeouts between 3 and 50 written by the bench bring every event selection, kicks from both the running and the expired states, and the timeout lock within a short run. They also place every edge of the countdown at a known cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_RUN     = 2'd1,
        ST_EXPIRED = 2'd2
    } wdog_state_t;

    // register addresses
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_TMO  = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    // control word layout
    localparam int CTRL_W    = 16;
    localparam int FLAG_BIT  = 15;
    localparam int FIELD_LSB = 4;
    localparam int FIELD_W   = 8;
    localparam int SEL_LSB   = 1;
    localparam int SEL_W     = 2;
    localparam int NUM_EVT   = 3;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int                 CNT_W       = 32,
    parameter logic [FIELD_W-1:0] OFF_KEY     = 8'hAD,
    parameter logic [CNT_W-1:0]   RST_TIMEOUT = 32'h0800_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [1:0]       addr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             fire,
    input  logic [CNT_W-1:0] remain,
    output logic             en,
    output logic [SEL_W-1:0] sel,
    output logic             flag,
    output logic [CNT_W-1:0] period,
    output logic             kick,
    output logic [CNT_W-1:0] rdata
);

    localparam int FIELD_MSB = FIELD_LSB + FIELD_W - 1;
    localparam int SEL_MSB   = SEL_LSB + SEL_W - 1;

    logic [FIELD_W-1:0] field_q;
    logic [SEL_W-1:0]   sel_q;
    logic               flag_q;
    logic [CNT_W-1:0]   period_q;
    logic               wr_ctrl, wr_tmo;
    logic [CTRL_W-1:0]  ctrl_view;

    assign wr_ctrl = wr && (addr == ADDR_CTRL);
    assign wr_tmo  = wr && (addr == ADDR_TMO);
    assign kick    = wr && (addr == ADDR_STAT);
    assign en      = (field_q != OFF_KEY);
    assign sel     = sel_q;
    assign flag    = flag_q;
    assign period  = period_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            field_q <= OFF_KEY;
            sel_q   <= '0;
        end else if (wr_ctrl) begin
            field_q <= wdata[FIELD_MSB:FIELD_LSB];
            sel_q   <= wdata[SEL_MSB:SEL_LSB];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (fire) begin
            flag_q <= 1'b1;
        end else if (wr_ctrl && wdata[FLAG_BIT]) begin
            flag_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q <= RST_TIMEOUT;
        end else if (wr_tmo && !en) begin
            period_q <= wdata;
        end
    end

    always_comb begin
        ctrl_view = '0;
        ctrl_view[FLAG_BIT]            = flag_q;
        ctrl_view[FIELD_MSB:FIELD_LSB] = field_q;
        ctrl_view[SEL_MSB:SEL_LSB]     = sel_q;
    end

    always_comb begin
        unique case (addr)
            ADDR_CTRL: rdata = CNT_W'(ctrl_view);
            ADDR_TMO:  rdata = period_q;
            ADDR_STAT: rdata = remain;
            default:   rdata = '0;
        endcase
    end

    // R9: a timeout write while enabled leaves the timeout untouched
    a_r9_tmo_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tmo && en) |=> $stable(period_q));

    // R5: expiry always leaves the flag set
    a_r5_flag_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> flag_q);

    // R7: a control write without bit 15 never clears the flag
    a_r7_flag_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && wr_ctrl && !wdata[FLAG_BIT]) |=> flag_q);

endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             kick,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] remain,
    output logic             fire
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    wdog_state_t      state_q, state_d;
    logic [CNT_W-1:0] remain_q, remain_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_OFF;
            remain_q <= '0;
        end else begin
            state_q  <= state_d;
            remain_q <= remain_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        remain_d = remain_q;
        fire     = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                if (en) begin                      // arm
                    state_d  = ST_RUN;
                    remain_d = period;
                end
            end
            ST_RUN: begin
                if (!en) begin                     // disarm
                    state_d = ST_OFF;
                end else if (kick) begin           // kick
                    remain_d = period;
                end else if (remain_q <= ONE) begin // fire
                    remain_d = '0;
                    state_d  = ST_EXPIRED;
                    fire     = 1'b1;
                end else begin
                    remain_d = remain_q - ONE;
                end
            end
            ST_EXPIRED: begin
                if (!en) begin                     // disarm
                    state_d = ST_OFF;
                end else if (kick) begin           // kick
                    state_d  = ST_RUN;
                    remain_d = period;
                end
            end
            default: begin
                state_d  = ST_OFF;
                remain_d = remain_q;
            end
        endcase
    end

    assign remain = remain_q;

    // R2: while disabled the remaining count does not move
    a_r2_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(remain_q));

    // R4: steady countdown by one per clock
    a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && en && !kick && remain_q > ONE)
        |=> (remain_q == $past(remain_q) - ONE));

    // R5: expired count stays at zero until kicked or disabled
    a_r5_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXPIRED && en && !kick) |=> (remain_q == '0));

    // R8: a kick while enabled reloads the timeout
    a_r8_kick_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_OFF && en && kick) |=> (remain_q == $past(period)));

endmodule

// File: rtl/wdog_event.sv
module wdog_event
    import wdog_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fire,
    input  logic [SEL_W-1:0]   sel,
    output logic [NUM_EVT-1:0] req
);

    logic [NUM_EVT-1:0] req_q;

    for (genvar gi = 0; gi < NUM_EVT; gi++) begin : g_evt
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                req_q[gi] <= 1'b0;
            end else begin
                req_q[gi] <= fire && (sel == SEL_W'(gi));
            end
        end
    end

    assign req = req_q;

    // R6: never more than one event line at once
    a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_q));

    // R5: each event is a single-cycle pulse
    a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q != '0) |=> (req_q == '0));

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import wdog_pkg::*;
#(
    parameter int                 CNT_W       = 32,
    parameter logic [FIELD_W-1:0] OFF_KEY     = 8'hAD,
    parameter logic [CNT_W-1:0]   RST_TIMEOUT = 32'h0800_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             rst_req,
    output logic             nmi_req,
    output logic             irq_req,
    output logic             expired
);

    logic               en, kick, fire, flag;
    logic [SEL_W-1:0]   sel;
    logic [CNT_W-1:0]   period, remain;
    logic [NUM_EVT-1:0] req;

    wdog_regs #(
        .CNT_W       (CNT_W),
        .OFF_KEY     (OFF_KEY),
        .RST_TIMEOUT (RST_TIMEOUT)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .fire   (fire),
        .remain (remain),
        .en     (en),
        .sel    (sel),
        .flag   (flag),
        .period (period),
        .kick   (kick),
        .rdata  (bus_rdata)
    );

    wdog_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .kick   (kick),
        .period (period),
        .remain (remain),
        .fire   (fire)
    );

    wdog_event u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (fire),
        .sel   (sel),
        .req   (req)
    );

    assign rst_req = req[0];
    assign nmi_req = req[1];
    assign irq_req = req[2];
    assign expired = flag;

    // R5: an event pulse coincides with the flag being set
    a_r5_evt_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req || nmi_req || irq_req) |-> expired);

endmodule

// File: tb/sim_keyed_watchdog.sv
`timescale 1ns/1ps
module sim_keyed_watchdog;

    localparam int          CNT_W = 32;
    localparam logic [31:0] RST_T = 32'd20;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_wr = 1'b0;
    logic [1:0]       bus_addr = 2'd0;
    logic [CNT_W-1:0] bus_wdata = '0;
    logic [CNT_W-1:0] bus_rdata;
    logic             rst_req, nmi_req, irq_req, expired;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    keyed_watchdog #(.CNT_W(CNT_W), .OFF_KEY(8'hAD), .RST_TIMEOUT(RST_T)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req),
        .nmi_req(nmi_req), .irq_req(irq_req), .expired(expired)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] evts();
        return {29'd0, irq_req, nmi_req, rst_req};
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        rd(2'd0, v); check("R1 ctrl", v, 32'h0AD0);
        rd(2'd1, v); check("R1 timeout", v, RST_T);
        rd(2'd2, v); check("R1 status", v, 0);
        check("R1 outputs", {evts(), expired}, 0);
    endtask

    task automatic t_default_expiry();
        logic [31:0] v;
        wr(2'd0, 32'h0000);               // R3: zero enables, reset action
        cyc(20);
        rd(2'd2, v); check("R5 status one before expiry", v, 1);
        check("R5 no event yet", evts(), 0);
        cyc(1);
        rd(2'd2, v); check("R5 status zero", v, 0);
        check("R3 rst_req pulse", evts(), 32'h1);
        check("R5 expired set", {31'd0, expired}, 1);
        cyc(1);
        check("R5 pulse one cycle", evts(), 0);
        cyc(3);
        rd(2'd2, v); check("R5 holds zero", v, 0);
        wr(2'd0, 32'h8AD0);
        check("R7 flag cleared", {31'd0, expired}, 0);
    endtask

    task automatic t_enable_load();
        logic [31:0] v;
        wr(2'd1, 32'd10);
        wr(2'd0, 32'h0006);
        cyc(1);
        rd(2'd2, v); check("R4 load on enable", v, 10);
        cyc(3);
        rd(2'd2, v); check("R4 count down", v, 7);
        wr(2'd0, 32'h0AD6);
    endtask

    task automatic t_keyed_disable();
        logic [31:0] a, b;
        wr(2'd1, 32'd50);
        wr(2'd0, 32'h0006);
        cyc(5);
        wr(2'd0, 32'h0AD6);
        rd(2'd2, a);
        cyc(8);
        rd(2'd2, b); check("R2 status held", b, a);
        check("R2 no event", {evts(), expired}, 0);
        wr(2'd0, 32'h0AC6);               // R3: non-key value enables
        cyc(2);
        rd(2'd2, b); check("R3 other field value counts", b, 49);
        wr(2'd0, 32'h0AD6);
    endtask

    task automatic t_event_select();
        for (int s = 0; s < 4; s++) begin
            logic [31:0] exp;
            exp = (s == 3) ? 32'h0 : (32'h1 << s);
            wr(2'd1, 32'd4);
            wr(2'd0, 32'(s) << 1);
            cyc(5);
            check($sformatf("R6 event sel=%0d", s), evts(), exp);
            check("R5 flag at expiry", {31'd0, expired}, 1);
            cyc(1);
            check("R6 event cleared", evts(), 0);
            wr(2'd0, 32'h8AD0);
        end
    endtask

    task automatic t_flag_w1c();
        logic [31:0] v, a;
        wr(2'd1, 32'd3);
        wr(2'd0, 32'h0006);
        cyc(6);
        wr(2'd0, 32'h0AD6);
        check("R7 zero write keeps flag", {31'd0, expired}, 1);
        rd(2'd0, v); check("R7 ctrl shows flag", v, 32'h8AD6);
        wr(2'd0, 32'h8AD6);
        check("R7 w1c clears", {31'd0, expired}, 0);
        rd(2'd0, v); check("R7 ctrl after clear", v, 32'h0AD6);
        rd(2'd2, a); wr(2'd1, 32'd9); cyc(3);
        rd(2'd2, v); check("R7 stays disabled", v, a);
    endtask

    task automatic t_kick();
        logic [31:0] v, a;
        wr(2'd1, 32'd10);
        wr(2'd0, 32'h0006);
        cyc(6);
        rd(2'd2, v); check("R4 mid count", v, 5);
        wr(2'd2, 32'h1234);
        rd(2'd2, v); check("R8 kick reloads", v, 10);
        cyc(9);
        rd(2'd2, v); check("R8 count after kick", v, 1);
        cyc(1);
        check("R5 expired after kick run", {31'd0, expired}, 1);
        wr(2'd2, 32'h0);
        rd(2'd2, v); check("R8 kick from expired", v, 10);
        check("R8 flag sticky", {31'd0, expired}, 1);
        cyc(1);
        rd(2'd2, v); check("R8 counting again", v, 9);
        wr(2'd0, 32'h8AD6);
        rd(2'd2, a);
        wr(2'd2, 32'h0);
        rd(2'd2, v); check("R8 kick ignored when disabled", v, a);
    endtask

    task automatic t_tmo_lock();
        logic [31:0] v;
        wr(2'd1, 32'd12);
        rd(2'd1, v); check("R9 write while disabled", v, 12);
        wr(2'd0, 32'h0006);
        wr(2'd1, 32'd99);
        rd(2'd1, v); check("R9 write while enabled ignored", v, 12);
        wr(2'd2, 32'h0);
        rd(2'd2, v); check("R9 kick uses kept timeout", v, 12);
        wr(2'd0, 32'h0AD6);
        wr(2'd1, 32'd7);
        rd(2'd1, v); check("R9 write after disable", v, 7);
    endtask

    task automatic t_regmap();
        logic [31:0] v;
        wr(2'd0, 32'h0AD5);
        rd(2'd0, v); check("R10 ctrl format", v, 32'h0AD4);
        rd(2'd3, v); check("R10 addr3 zero", v, 0);
        wr(2'd0, 32'h0AD0);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_default_expiry();
        t_enable_load();
        t_keyed_disable();
        t_event_select();
        t_flag_w1c();
        t_kick();
        t_tmo_lock();
        t_regmap();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule